// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a two-wire bus target with a fixed 7-bit device address. It gives a host access to a small bank of 8-bit configuration registers that are selected by an 8-bit register index. SCL and SDA arrive as asynchronous inputs and are resampled on the system clock. The block pulls SDA low through an open-drain output enable and otherwise leaves the line alone. A host writes one register per transaction. To read, the host first writes the register index, then issues a repeated START and reads a single byte.

Register 0 is a command register: setting its bit 0 returns the entire bank to its default contents. Register 1 holds an 8-bit power-down mask with one bit per lane and drives the `lane_pd` output. The remaining mapped registers appear side by side on `cfg_out`.

Top module: `smb_cfg_target`

## Requirements
- R1: A transaction opens with START, then seven address bits and a direction bit, sent MSB first. Direction 0 is a write and 1 is a read. The target ACKs the address byte (SDA low during the ninth clock) only when the seven bits equal `DEV_ADDR`.
- R2: A write is START, address+0, register index, data, STOP. The target ACKs all three bytes and stores the data byte in the indexed register.
- R3: A read is START, address+0, register index, repeated START, address+1. The target ACKs both address bytes and the index, then shifts out the indexed register MSB first. The register index survives the repeated START.
- R4: After the read byte the host answers with NACK. The target then leaves SDA released for every further clock until the next START or STOP.
- R5: Writing a byte with bit 0 set to register 0 restores every register to 0x00, which is the default of every register. Register 0 reads back as 0x00 after the restore.
- R6: Register 1 drives `lane_pd` directly. Bit n set means lane n is powered down. The value is 0x00 after reset, meaning all lanes are on.
- R7: Register k (2 ≤ k < `NUM_REGS`) drives `cfg_out[(k-2)*8 +: 8]`. All of them are 0x00 after reset.
- R8: Indices at or above `NUM_REGS` read as 0x00. Writes to them are ACKed and change no register.
- R9: When the address does not match, the target drives no ACK and keeps SDA released until the next START.
- R10: The target changes its SDA drive only while SCL is low.
- R11: START or STOP at any point aborts the byte in progress. A STOP before the data byte is complete leaves the registers unchanged, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| lane_pd | output | 8 | Per-lane power-down mask (register 1) |
| cfg_out | output | (NUM_REGS-2)*8 | Registers 2 and up, register 2 in the low byte |

## Verification
The assertions assume a bus that the system clock oversamples well. Each SCL level has to last several clocks beyond the two-stage synchronizer, and a host changes SDA only in the middle of SCL low, except when it deliberately signals START or STOP. The assertions also assume that only the target pulls SDA low while the target holds its ACK or data bit. The stimulus meets these assumptions with a host model whose every bus phase lasts eight clocks. The model combines the line as a wired AND of its own drive and the target's enable, and it forms START and STOP only while it has released the line.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_INDEX,
    LK_INDEX_ACK,
    LK_DATA,
    LK_DATA_ACK,
    LK_SEND,
    LK_SEND_ACK,
    LK_PARK
  } link_state_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q, stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          stab_q <= 1'b1;
        end else begin
          meta_q <= d[i];
          stab_q <= meta_q;
        end
      end
      assign q[i] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] reg_ptr
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  link_state_t   state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic          scl_d, sda_d;

  logic scl_rise, scl_fall, start_c, stop_c, byte_full;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_c   = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c    = scl_s & scl_d & ~sda_d & sda_s;
  assign byte_full = (cnt_q == FULL);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    wr_en   = 1'b0;
    if (start_c) begin
      state_n = LK_ADDR;
      cnt_n   = '0;
    end else if (stop_c) begin
      state_n = LK_IDLE;
      cnt_n   = '0;
    end else begin
      case (state_q)
        LK_ADDR, LK_INDEX, LK_DATA: begin
          if (scl_rise && !byte_full) begin
            sh_n  = {sh_q[DW-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && byte_full) begin
            cnt_n = '0;
            if (state_q == LK_ADDR) begin
              state_n = (sh_q[DW-1:1] == DEV_ADDR) ? LK_ADDR_ACK : LK_PARK;
            end else if (state_q == LK_INDEX) begin
              ptr_n   = AW'(sh_q);
              state_n = LK_INDEX_ACK;
            end else begin
              wr_en   = 1'b1;
              state_n = LK_DATA_ACK;
            end
          end
        end
        LK_ADDR_ACK: begin
          if (scl_fall) begin
            if (sh_q[0]) begin
              state_n = LK_SEND;
              sh_n    = rd_data;
            end else begin
              state_n = LK_INDEX;
            end
          end
        end
        LK_INDEX_ACK: if (scl_fall) state_n = LK_DATA;
        LK_DATA_ACK:  if (scl_fall) state_n = LK_PARK;
        LK_SEND: begin
          if (scl_rise && !byte_full) begin
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (byte_full) begin
              cnt_n   = '0;
              state_n = LK_SEND_ACK;
            end else begin
              sh_n = {sh_q[DW-2:0], 1'b0};
            end
          end
        end
        LK_SEND_ACK: if (scl_rise) state_n = LK_PARK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      scl_d   <= scl_s;
      sda_d   <= sda_s;
    end
  end

  assign sda_oe  = (state_q == LK_ADDR_ACK) || (state_q == LK_INDEX_ACK) ||
                   (state_q == LK_DATA_ACK) || ((state_q == LK_SEND) && !sh_q[DW-1]);
  assign wr_data = sh_q;
  assign reg_ptr = ptr_q;

  // R10: drive only moves while the resampled clock is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_d) |-> $stable(sda_oe));

  // R9: a foreign address leads to a released line
  p_no_ack_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_ADDR && scl_fall && byte_full && !start_c && !stop_c &&
     sh_q[DW-1:1] != DEV_ADDR) |=> !sda_oe);

  // R4: once the read byte is over, the line is released
  p_release_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LK_SEND_ACK || state_q == LK_PARK) |-> !sda_oe);

  // R11: a bus condition always restarts the byte counter
  p_restart_on_condition_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> (cnt_q == '0) && !sda_oe);
endmodule

// File: rtl/smb_regs.sv
module smb_regs #(
  parameter int NUM_REGS = 8,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [DW-1:0]            lane_pd,
  output logic [(NUM_REGS-2)*DW-1:0] cfg_out
);
  logic          restore_q, restore_n;
  logic [DW-1:0] mem_q [NUM_REGS-1:1];

  assign restore_n = wr_en && (wr_addr == '0) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restore_q <= 1'b0;
    else        restore_q <= restore_n;
  end

  generate
    for (genvar k = 1; k < NUM_REGS; k++) begin : g_reg
      logic          load;
      logic [DW-1:0] next_val;
      assign load     = restore_q || (wr_en && (wr_addr == AW'(k)));
      assign next_val = restore_q ? '0 : wr_data;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mem_q[k] <= '0;
        else if (load) mem_q[k] <= next_val;
      end
    end
    for (genvar k = 2; k < NUM_REGS; k++) begin : g_out
      assign cfg_out[(k-2)*DW +: DW] = mem_q[k];
    end
  endgenerate

  assign lane_pd = mem_q[1];

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = {{(DW-1){1'b0}}, restore_q};
    for (int k = 1; k < NUM_REGS; k++) begin
      if (rd_addr == AW'(k)) rd_data = mem_q[k];
    end
  end

  // R5: restore strobe lasts one cycle and clears the bank
  p_restore_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |=> !restore_q);
  p_restore_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_q |=> (lane_pd == '0) && (cfg_out == '0));

  // R6: a write to register 1 lands on the lane mask
  p_lane_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(1) && !restore_q) |=> (lane_pd == $past(wr_data)));

  // R8: writes past the bank leave every register as it was
  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= AW'(NUM_REGS) && !restore_q) |=>
      ($stable(lane_pd) && $stable(cfg_out)));
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h5C,
  parameter int         NUM_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  output logic [7:0]                lane_pd,
  output logic [(NUM_REGS-2)*8-1:0] cfg_out
);
  localparam int AW = 8;
  localparam int DW = 8;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [1:0]    bus_s;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW-1:0] reg_ptr;

  smb_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({scl_i, sda_i}),
    .q     (bus_s)
  );

  smb_link #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_link (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_s   (bus_s[1]),
    .sda_s   (bus_s[0]),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .reg_ptr (reg_ptr)
  );

  smb_regs #(.NUM_REGS(NUM_REGS), .AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (reg_ptr),
    .wr_data (wr_data),
    .rd_addr (reg_ptr),
    .rd_data (rd_data),
    .lane_pd (lane_pd),
    .cfg_out (cfg_out)
  );
endmodule

// File: tb/smb_cfg_target_test.sv
module smb_cfg_target_test;
  localparam logic [6:0] DEV = 7'h5C;
  localparam int NR = 8;
  localparam int CW = (NR-2)*8;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [7:0] lane_pd;
  logic [CW-1:0] cfg_out;
  logic sda;
  assign sda = sda_h & ~sda_oe;

  always #10 clk = ~clk;

  smb_cfg_target #(.DEV_ADDR(DEV), .NUM_REGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .lane_pd(lane_pd), .cfg_out(cfg_out)
  );

  int tests = 0;
  int fails = 0;
  int r10_viol = 0;
  logic [7:0] model [0:NR-1];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 monitor: drive must not move while SCL stays high
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_p && (sda_oe !== oe_p)) r10_viol++;
    scl_p = scl;
    oe_p  = sda_oe;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); ack = (sda == 1'b0); wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda; wq(); scl = 1'b0; wq();
    end
    send_bit(nack);
  endtask

  task automatic write_reg(input logic [6:0] dev, input logic [7:0] r, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({dev, 1'b0}, a0);
    send_byte(r, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] r, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte(r, a1);
    bus_start();
    send_byte({DEV, 1'b1}, a2);
    recv_byte(1'b1, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  function automatic void model_write(input logic [7:0] r, input logic [7:0] d);
    if (r == 8'd0) begin
      if (d[0]) for (int k = 0; k < NR; k++) model[k] = 8'h00;
    end else if (r < 8'(NR)) model[r] = d;
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] r);
    return (r < 8'(NR)) ? model[r] : 8'h00;
  endfunction

  function automatic logic [CW-1:0] model_cfg();
    logic [CW-1:0] v;
    for (int k = 2; k < NR; k++) v[(k-2)*8 +: 8] = model[k];
    return v;
  endfunction

  task automatic check_outputs(input string tag);
    check(lane_pd == model[1], {tag, " R6 lane_pd"}, 64'(lane_pd), 64'(model[1]));
    check(cfg_out == model_cfg(), {tag, " R7 cfg_out"}, 64'(cfg_out), 64'(model_cfg()));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [7:0] rd;
    for (int k = 0; k < NR; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // Reset state: R6, R7
    check(sda_oe == 1'b0, "R10 reset release", 64'(sda_oe), 64'd0);
    check_outputs("reset");

    // Sweep every index (mapped and unmapped) with three patterns: R1 R2 R3 R5 R8
    for (int r = 0; r < NR + 4; r++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'h5A : (p == 1) ? 8'hC3 : 8'(r * 37 + 11);
        write_reg(DEV, 8'(r), d, ok);
        model_write(8'(r), d);
        check(ok, "R2/R8 write acks", 64'(ok), 64'd1);
        check_outputs("sweep");
        read_reg(8'(r), rd, ok);
        check(ok, "R1/R3 read acks", 64'(ok), 64'd1);
        check(rd == model_read(8'(r)), "R3/R5/R8 readback", 64'(rd), 64'(model_read(8'(r))));
      end
    end

    // Fill then soft restore: R5
    for (int k = 1; k < NR; k++) begin
      write_reg(DEV, 8'(k), 8'(8'hF0 + k), ok);
      model_write(8'(k), 8'(8'hF0 + k));
    end
    check_outputs("R5 pre-fill");
    write_reg(DEV, 8'h00, 8'h01, ok);
    model_write(8'h00, 8'h01);
    check(ok, "R5 restore write ack", 64'(ok), 64'd1);
    check(lane_pd == 8'h00 && cfg_out == '0, "R5 bank cleared", 64'(lane_pd), 64'd0);
    read_reg(8'h00, rd, ok);
    check(rd == 8'h00, "R5 control reads zero", 64'(rd), 64'd0);

    // Foreign address: R9
    write_reg(DEV, 8'h01, 8'h3E, ok);
    model_write(8'h01, 8'h3E);
    write_reg(DEV ^ 7'h01, 8'h01, 8'h77, ok);
    check(!ok, "R9 no ack for foreign address", 64'(ok), 64'd0);
    check(lane_pd == 8'h3E, "R9 foreign write ignored", 64'(lane_pd), 64'h3E);

    // Stop inside the data byte: R11
    begin
      logic a0, a1;
      bus_start();
      send_byte({DEV, 1'b0}, a0);
      send_byte(8'h02, a1);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop();
      check(cfg_out[7:0] == model[2], "R11 partial write dropped", 64'(cfg_out[7:0]), 64'(model[2]));
      write_reg(DEV, 8'h02, 8'h96, ok);
      model_write(8'h02, 8'h96);
      check(ok && cfg_out[7:0] == 8'h96, "R11 recovery write", 64'(cfg_out[7:0]), 64'h96);
    end

    // Released line after NACK: R4
    begin
      logic a0, a1, a2;
      logic [7:0] extra;
      bus_start();
      send_byte({DEV, 1'b0}, a0);
      send_byte(8'h02, a1);
      bus_start();
      send_byte({DEV, 1'b1}, a2);
      recv_byte(1'b1, rd);
      recv_byte(1'b1, extra);
      bus_stop();
      check(rd == 8'h96, "R3 read before NACK", 64'(rd), 64'h96);
      check(extra == 8'hFF, "R4 line released after NACK", 64'(extra), 64'hFF);
    end

    check(r10_viol == 0, "R10 drive changes with SCL high", 64'(r10_viol), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule